// File: doc/BRIEF.md
# Memory Operation Hazard Matrix

This block holds memory operations that already have a physical address (loads, stores, fences and atomic read-modify-writes) while they wait for a load/store unit. Every commit-queue slot owns exactly one entry, and the entry is indexed by that slot number. When an address unit writes an entry, the block compares it with every live entry and with every entry written in the same cycle. It then records a per-entry bit vector that names the older entries which must leave first. The block drives a ready vector. An entry is ready when it is live and its blocking vector is empty. A separate vector flags the ready entries that are loads, so the scheduler can serve loads first.

Program order comes from the commit-queue head pointer. An entry's age is its slot minus the head, modulo the slot count, which must be a power of two. Only an older entry can block a younger one. An older slot whose memory operation has no address yet blocks every younger entry written after it. When that older slot is later written, the block replaces its bit in every younger entry with the result of the real overlap test. A release port removes entries, and a flush port removes every entry younger than a given slot. In both cases the departing entries' columns are cleared from all the remaining vectors. An entry written this cycle with no blockers shows as ready in the same cycle.

Top module: `phb_hazard_buf`

## Requirements
- R1: After reset no entry is live and both `ready_o` and `ready_ld_o` are all zero.
- R2: An entry written with no blockers shows in `ready_o` in the same cycle as the write, and it stays ready in the following cycles until it leaves.
- R3: Operation codes are 2'b00 load, 2'b01 store, 2'b10 fence and 2'b11 atomic. A younger entry is blocked by an older store, or by an older entry of any kind when the younger entry is a store, if both have the same word address and their byte masks share at least one set bit. A different word address, or disjoint masks, does not block.
- R4: Two loads never block each other, even when they touch the same bytes.
- R5: An older fence or atomic blocks every younger entry. A fence or atomic is blocked by every older live entry.
- R6: Age is measured from `head_i`, including across the wrap of the slot index. When an older entry is written after a younger one, the younger entry gains the blocking bit and the older one stays unblocked.
- R7: A released entry leaves at the next clock edge and its bit is cleared in every other entry. An entry whose last blocker is released is ready in the cycle after the release.
- R8: A slot flagged in `mem_wait_i` that is older and not yet written blocks younger entries. When that slot is written, each younger entry's bit for it becomes the result of the real overlap test.
- R9: A flush removes every entry younger than `flush_slot_i` and clears their bits from all the survivors. A later write to a flushed slot sees no stale state.
- R10: `ready_ld_o` is the subset of `ready_o` whose entries are loads.
- R11: Entries written on different ports in the same cycle are checked against each other in age order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_i | input | IDX_W | Slot of the oldest commit-queue entry |
| mem_wait_i | input | NSLOT | Slots holding a memory operation that is not yet translated |
| wr_vld_i | input | NWR | Write strobe, one per address-unit port |
| wr_slot_i | input | NWR*IDX_W | Target slot, one per port |
| wr_op_i | input | NWR*2 | Operation code, one per port |
| wr_addr_i | input | NWR*ADDR_W | Physical word address, one per port |
| wr_mask_i | input | NWR*8 | Byte mask within the 64-bit word, one per port |
| rel_vld_i | input | NREL | Release strobe, one per load/store unit |
| rel_slot_i | input | NREL*IDX_W | Slot being released, one per unit |
| flush_i | input | 1 | Flush strobe |
| flush_slot_i | input | IDX_W | Youngest surviving slot on a flush |
| ready_o | output | NSLOT | Entries that are live with no blockers (same-cycle writes included) |
| ready_ld_o | output | NSLOT | Ready entries that are loads |

## Verification
The bench builds the block with eight slots, two write ports, two release ports and a 12-bit word address. With eight slots, a single sequence can fill the buffer with a store, loads, a fence and an atomic and then drain it one release at a time. Because there are two write ports, same-cycle pairs can be tested: an older store next to a younger load, a store next to an older load, and two entries that refine each other. Moving the head to slot 6 makes the slot index wrap, so an entry in slot 7 is older than one in slot 1.

// File: rtl/phb_pkg.sv
package phb_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10,
        OP_AMO   = 2'b11
    } mem_op_e;

    localparam int BYTES_PER_WORD = 8;

endpackage

// File: rtl/phb_pair_cmp.sv
module phb_pair_cmp
    import phb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]                op_a,
    input  logic [ADDR_W-1:0]         addr_a,
    input  logic [BYTES_PER_WORD-1:0] mask_a,
    input  logic [1:0]                op_b,
    input  logic [ADDR_W-1:0]         addr_b,
    input  logic [BYTES_PER_WORD-1:0] mask_b,
    output logic                      clash_o
);

    logic orders_a;
    logic orders_b;
    logic has_store;
    logic bytes_meet;

    always_comb begin
        orders_a   = (op_a == OP_FENCE) || (op_a == OP_AMO);
        orders_b   = (op_b == OP_FENCE) || (op_b == OP_AMO);
        has_store  = (op_a == OP_STORE) || (op_b == OP_STORE);
        bytes_meet = (addr_a == addr_b) && (|(mask_a & mask_b));
        clash_o    = orders_a || orders_b || (has_store && bytes_meet);
    end

endmodule

// File: rtl/phb_wr_lane.sv
module phb_wr_lane
    import phb_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic [IDX_W-1:0]                           head_i,
    input  logic [IDX_W-1:0]                           my_slot_i,
    input  logic [1:0]                                 my_op_i,
    input  logic [ADDR_W-1:0]                          my_addr_i,
    input  logic [BYTES_PER_WORD-1:0]                  my_mask_i,
    input  logic [NSLOT-1:0]                           view_vld_i,
    input  logic [NSLOT-1:0][1:0]                      view_op_i,
    input  logic [NSLOT-1:0][ADDR_W-1:0]               view_addr_i,
    input  logic [NSLOT-1:0][BYTES_PER_WORD-1:0]       view_mask_i,
    input  logic [NSLOT-1:0]                           wait_i,
    output logic [NSLOT-1:0]                           row_o,
    output logic [NSLOT-1:0]                           col_o
);

    logic [IDX_W-1:0] my_age;
    assign my_age = my_slot_i - head_i;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [IDX_W-1:0] s_age;
        logic             clash;
        logic             is_older;
        logic             is_younger;

        assign s_age = IDX_W'(s) - head_i;

        phb_pair_cmp #(.ADDR_W(ADDR_W)) cmp_i (
            .op_a    (view_op_i[s]),
            .addr_a  (view_addr_i[s]),
            .mask_a  (view_mask_i[s]),
            .op_b    (my_op_i),
            .addr_b  (my_addr_i),
            .mask_b  (my_mask_i),
            .clash_o (clash)
        );

        always_comb begin
            is_older   = s_age < my_age;
            is_younger = s_age > my_age;
            row_o[s]   = is_older && (view_vld_i[s] ? clash : wait_i[s]);
            col_o[s]   = is_younger && view_vld_i[s] && clash;
        end
    end

endmodule

// File: rtl/phb_hazard_buf.sv
module phb_hazard_buf
    import phb_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int NWR    = 2,
    parameter int NREL   = 2,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(NSLOT),
    localparam int MW    = BYTES_PER_WORD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      head_i,
    input  logic [NSLOT-1:0]      mem_wait_i,
    input  logic [NWR-1:0]        wr_vld_i,
    input  logic [NWR*IDX_W-1:0]  wr_slot_i,
    input  logic [NWR*2-1:0]      wr_op_i,
    input  logic [NWR*ADDR_W-1:0] wr_addr_i,
    input  logic [NWR*MW-1:0]     wr_mask_i,
    input  logic [NREL-1:0]       rel_vld_i,
    input  logic [NREL*IDX_W-1:0] rel_slot_i,
    input  logic                  flush_i,
    input  logic [IDX_W-1:0]      flush_slot_i,
    output logic [NSLOT-1:0]      ready_o,
    output logic [NSLOT-1:0]      ready_ld_o
);

    typedef struct packed {
        logic [NSLOT-1:0]              vld;
        logic [NSLOT-1:0][1:0]         op;
        logic [NSLOT-1:0][ADDR_W-1:0]  addr;
        logic [NSLOT-1:0][MW-1:0]      mask;
        logic [NSLOT-1:0][NSLOT-1:0]   haz;
    } buf_st_t;

    buf_st_t st_d, st_q;

    // Port unpacking
    logic [NWR-1:0][IDX_W-1:0]  wr_slot;
    logic [NWR-1:0][1:0]        wr_op;
    logic [NWR-1:0][ADDR_W-1:0] wr_addr;
    logic [NWR-1:0][MW-1:0]     wr_mask;
    logic [NREL-1:0][IDX_W-1:0] rel_slot;

    assign wr_slot  = wr_slot_i;
    assign wr_op    = wr_op_i;
    assign wr_addr  = wr_addr_i;
    assign wr_mask  = wr_mask_i;
    assign rel_slot = rel_slot_i;

    // Decoded per-slot events and the merged view seen by the lanes
    logic [NSLOT-1:0]             kill;
    logic [NSLOT-1:0]             rel_hit;
    logic [NSLOT-1:0]             wr_hit;
    logic [NSLOT-1:0]             view_vld;
    logic [NSLOT-1:0][1:0]        view_op;
    logic [NSLOT-1:0][ADDR_W-1:0] view_addr;
    logic [NSLOT-1:0][MW-1:0]     view_mask;
    logic [NSLOT-1:0]             wait_live;
    logic [IDX_W-1:0]             flush_age;

    always_comb begin
        flush_age = flush_slot_i - head_i;
        kill      = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (flush_i && ((IDX_W'(s) - head_i) > flush_age)) begin
                kill[s] = 1'b1;
            end
        end

        rel_hit = '0;
        for (int r = 0; r < NREL; r++) begin
            if (rel_vld_i[r]) begin
                rel_hit[rel_slot[r]] = 1'b1;
            end
        end

        wr_hit    = '0;
        view_op   = st_q.op;
        view_addr = st_q.addr;
        view_mask = st_q.mask;
        for (int w = 0; w < NWR; w++) begin
            if (wr_vld_i[w]) begin
                wr_hit[wr_slot[w]]    = 1'b1;
                view_op[wr_slot[w]]   = wr_op[w];
                view_addr[wr_slot[w]] = wr_addr[w];
                view_mask[wr_slot[w]] = wr_mask[w];
            end
        end

        view_vld  = ((st_q.vld & ~rel_hit) | wr_hit) & ~kill;
        wait_live = mem_wait_i & ~kill;
    end

    // One comparison lane per write port
    logic [NWR-1:0][NSLOT-1:0] lane_row;
    logic [NWR-1:0][NSLOT-1:0] lane_col;

    for (genvar w = 0; w < NWR; w++) begin : g_lane
        phb_wr_lane #(
            .NSLOT  (NSLOT),
            .ADDR_W (ADDR_W)
        ) lane_i (
            .head_i      (head_i),
            .my_slot_i   (wr_slot[w]),
            .my_op_i     (wr_op[w]),
            .my_addr_i   (wr_addr[w]),
            .my_mask_i   (wr_mask[w]),
            .view_vld_i  (view_vld),
            .view_op_i   (view_op),
            .view_addr_i (view_addr),
            .view_mask_i (view_mask),
            .wait_i      (wait_live),
            .row_o       (lane_row[w]),
            .col_o       (lane_col[w])
        );
    end

    // Next state
    logic [NSLOT-1:0] gone_cols;

    always_comb begin
        st_d      = st_q;
        gone_cols = rel_hit | kill;
        for (int r = 0; r < NSLOT; r++) begin
            st_d.haz[r] = st_q.haz[r] & ~gone_cols;
        end
        for (int w = 0; w < NWR; w++) begin
            if (wr_vld_i[w] && !kill[wr_slot[w]]) begin
                st_d.op[wr_slot[w]]   = wr_op[w];
                st_d.addr[wr_slot[w]] = wr_addr[w];
                st_d.mask[wr_slot[w]] = wr_mask[w];
                st_d.haz[wr_slot[w]]  = lane_row[w];
                for (int k = 0; k < NSLOT; k++) begin
                    st_d.haz[k][wr_slot[w]] = lane_col[w][k];
                end
            end
        end
        st_d.vld = view_vld;
        for (int r = 0; r < NSLOT; r++) begin
            if (!st_d.vld[r]) begin
                st_d.haz[r] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Ready outputs with same-cycle bypass of written entries
    logic [NSLOT-1:0] rdy_held;
    logic [NSLOT-1:0] rdy_byp;

    always_comb begin
        rdy_byp = '0;
        for (int s = 0; s < NSLOT; s++) begin
            rdy_held[s] = st_q.vld[s] && (st_q.haz[s] == '0);
        end
        for (int w = 0; w < NWR; w++) begin
            if (wr_vld_i[w] && !kill[wr_slot[w]]) begin
                rdy_byp[wr_slot[w]] = (lane_row[w] == '0);
            end
        end
        ready_o = ((rdy_held & ~wr_hit) | rdy_byp) & ~kill;
        for (int s = 0; s < NSLOT; s++) begin
            ready_ld_o[s] = ready_o[s] && (view_op[s] == OP_LOAD);
        end
    end

    // Checks
    logic [NSLOT-1:0] col_any;

    always_comb begin
        col_any = '0;
        for (int r = 0; r < NSLOT; r++) begin
            col_any = col_any | st_q.haz[r];
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> (st_q.vld == '0));

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        // R2
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit[s] && !kill[s]) |=> st_q.vld[s]);

        // R7
        release_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_hit[s] && (wr_hit == '0)) |=> !col_any[s]);

        // R9
        idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.vld[s] |-> (st_q.haz[s] == '0));

        for (genvar c = 0; c < NSLOT; c++) begin : g_col
            // R6
            older_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.haz[s][c] |-> ((IDX_W'(c) - head_i) < (IDX_W'(s) - head_i)));
        end
    end

endmodule

// File: tb/phb_hazard_buf_tb_top.sv
`timescale 1ns/1ps
module phb_hazard_buf_tb_top;

    localparam int NSLOT  = 8;
    localparam int NWR    = 2;
    localparam int NREL   = 2;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 3;

    localparam logic [1:0] LD = 2'b00;
    localparam logic [1:0] ST = 2'b01;
    localparam logic [1:0] FE = 2'b10;
    localparam logic [1:0] AM = 2'b11;

    logic clk = 1'b0;
    logic rst_n;
    logic [IDX_W-1:0]             head;
    logic [NSLOT-1:0]             mem_wait;
    logic [NWR-1:0]               wr_vld;
    logic [NWR-1:0][IDX_W-1:0]    wr_slot;
    logic [NWR-1:0][1:0]          wr_op;
    logic [NWR-1:0][ADDR_W-1:0]   wr_addr;
    logic [NWR-1:0][7:0]          wr_mask;
    logic [NREL-1:0]              rel_vld;
    logic [NREL-1:0][IDX_W-1:0]   rel_slot;
    logic                         flush;
    logic [IDX_W-1:0]             flush_slot;
    logic [NSLOT-1:0]             ready_o;
    logic [NSLOT-1:0]             ready_ld_o;

    always #2 clk = ~clk;

    phb_hazard_buf #(
        .NSLOT(NSLOT), .NWR(NWR), .NREL(NREL), .ADDR_W(ADDR_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .head_i(head), .mem_wait_i(mem_wait),
        .wr_vld_i(wr_vld), .wr_slot_i(wr_slot), .wr_op_i(wr_op),
        .wr_addr_i(wr_addr), .wr_mask_i(wr_mask),
        .rel_vld_i(rel_vld), .rel_slot_i(rel_slot),
        .flush_i(flush), .flush_slot_i(flush_slot),
        .ready_o(ready_o), .ready_ld_o(ready_ld_o)
    );

    typedef struct packed {
        logic [1:0] act;      // 1 write on port 0, 2 release on port 0
        logic [2:0] slot;
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] mask;
        logic [7:0] exp_rdy;
    } step_t;

    localparam step_t SEQ [16] = '{
        '{2'd1, 3'd0, ST, 4'd1, 8'h0F, 8'h01},
        '{2'd1, 3'd1, LD, 4'd1, 8'h03, 8'h01},
        '{2'd1, 3'd2, LD, 4'd1, 8'hF0, 8'h05},
        '{2'd1, 3'd3, LD, 4'd2, 8'h0F, 8'h0D},
        '{2'd1, 3'd4, FE, 4'd0, 8'h00, 8'h0D},
        '{2'd1, 3'd5, LD, 4'd7, 8'hFF, 8'h0D},
        '{2'd2, 3'd0, LD, 4'd0, 8'h00, 8'h0E},
        '{2'd2, 3'd1, LD, 4'd0, 8'h00, 8'h0C},
        '{2'd2, 3'd2, LD, 4'd0, 8'h00, 8'h08},
        '{2'd2, 3'd3, LD, 4'd0, 8'h00, 8'h10},
        '{2'd2, 3'd4, LD, 4'd0, 8'h00, 8'h20},
        '{2'd2, 3'd5, LD, 4'd0, 8'h00, 8'h00},
        '{2'd1, 3'd6, AM, 4'd3, 8'hFF, 8'h40},
        '{2'd1, 3'd7, LD, 4'd9, 8'h01, 8'h40},
        '{2'd2, 3'd6, LD, 4'd0, 8'h00, 8'h80},
        '{2'd2, 3'd7, LD, 4'd0, 8'h00, 8'h00}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_vld = '0; wr_slot = '0; wr_op = '0; wr_addr = '0; wr_mask = '0;
        rel_vld = '0; rel_slot = '0; flush = 1'b0; flush_slot = '0;
    endtask

    task automatic put_wr(input int p, input logic [2:0] s, input logic [1:0] op,
                          input logic [ADDR_W-1:0] a, input logic [7:0] m);
        wr_vld[p] = 1'b1; wr_slot[p] = s; wr_op[p] = op; wr_addr[p] = a; wr_mask[p] = m;
    endtask

    task automatic put_rel(input int p, input logic [2:0] s);
        rel_vld[p] = 1'b1; rel_slot[p] = s;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; head = '0; mem_wait = '0;
        idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready in reset", ready_o, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 ready after reset", ready_o, 8'h00);
        chk("R1 ready_ld after reset", ready_ld_o, 8'h00);

        // Table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 16; i++) begin
            if (SEQ[i].act == 2'd1)
                put_wr(0, SEQ[i].slot, SEQ[i].op, {8'd0, SEQ[i].addr}, SEQ[i].mask);
            else
                put_rel(0, SEQ[i].slot);
            tick();
            chk($sformatf("R3 R4 R5 R7 table step %0d", i), ready_o, SEQ[i].exp_rdy);
        end

        // R2 R10: same-cycle bypass
        put_wr(0, 3'd2, LD, 12'h004, 8'hFF);
        #0.5;
        chk("R2 bypass ready", ready_o, 8'h04);
        chk("R10 bypass ready_ld", ready_ld_o, 8'h04);
        tick();
        chk("R2 held ready", ready_o, 8'h04);
        put_wr(0, 3'd3, ST, 12'h004, 8'h01);
        #0.5;
        chk("R2 blocked bypass", ready_o, 8'h04);
        tick();
        chk("R3 store after load", ready_o, 8'h04);
        put_rel(0, 3'd2);
        tick();
        chk("R7 store freed", ready_o, 8'h08);
        chk("R10 store not load", ready_ld_o, 8'h00);
        put_rel(0, 3'd3);
        tick();

        // R11: two ports in one cycle
        put_wr(0, 3'd1, ST, 12'h009, 8'h01);
        put_wr(1, 3'd2, LD, 12'h009, 8'h01);
        #0.5;
        chk("R11 same-cycle bypass", ready_o, 8'h02);
        tick();
        chk("R11 same-cycle held", ready_o, 8'h02);
        chk("R10 no ready load", ready_ld_o, 8'h00);
        put_rel(0, 3'd1);
        tick();
        chk("R10 load ready", ready_ld_o, 8'h04);
        put_rel(0, 3'd2);
        tick();

        // R6: older written after younger
        put_wr(0, 3'd3, LD, 12'h005, 8'hFF);
        tick();
        put_wr(0, 3'd1, ST, 12'h005, 8'h01);
        #0.5;
        chk("R6 late older bypass", ready_o, 8'h0A);
        tick();
        chk("R6 younger now blocked", ready_o, 8'h02);
        put_rel(0, 3'd1);
        put_rel(1, 3'd3);
        tick();
        chk("R7 dual release", ready_o, 8'h00);

        // R8: untranslated older slot
        mem_wait = 8'h02;
        put_wr(0, 3'd3, LD, 12'h005, 8'hFF);
        #0.5;
        chk("R8 waits on untranslated", ready_o, 8'h00);
        tick();
        put_wr(0, 3'd1, LD, 12'h005, 8'h01);
        tick();
        chk("R8 refined load-load", ready_o, 8'h0A);
        put_rel(0, 3'd1);
        put_rel(1, 3'd3);
        tick();
        put_wr(0, 3'd3, LD, 12'h005, 8'hFF);
        tick();
        put_wr(0, 3'd1, ST, 12'h005, 8'h01);
        tick();
        chk("R8 refined store-load", ready_o, 8'h02);
        put_rel(0, 3'd1);
        put_rel(1, 3'd3);
        tick();
        mem_wait = '0;

        // R9: flush
        put_wr(0, 3'd0, LD, 12'h001, 8'hFF);
        put_wr(1, 3'd2, ST, 12'h001, 8'hFF);
        tick();
        chk("R11 store behind load", ready_o, 8'h01);
        put_wr(0, 3'd3, LD, 12'h001, 8'h01);
        tick();
        chk("R3 load behind store", ready_o, 8'h01);
        flush = 1'b1;
        flush_slot = 3'd1;
        tick();
        chk("R9 after flush", ready_o, 8'h01);
        put_wr(0, 3'd2, LD, 12'h001, 8'h01);
        tick();
        chk("R9 no stale state", ready_o, 8'h05);
        put_rel(0, 3'd0);
        put_rel(1, 3'd2);
        tick();
        chk("R7 empty again", ready_o, 8'h00);

        // R6: wrap of the slot index
        head = 3'd6;
        put_wr(0, 3'd1, ST, 12'h002, 8'h0F);
        tick();
        chk("R6 wrap first", ready_o, 8'h02);
        put_wr(0, 3'd7, LD, 12'h002, 8'h01);
        tick();
        chk("R6 wrap older slot7", ready_o, 8'h80);
        put_rel(0, 3'd7);
        tick();
        chk("R6 wrap release", ready_o, 8'h02);
        put_rel(0, 3'd1);
        tick();
        chk("R7 wrap empty", ready_o, 8'h00);
        head = '0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule